// File: doc/BRIEF.md
# Control-Transfer Target Unit

This block works out where the program counter goes next for the control-transfer instructions of a 16-bit core, and what return address, if any, gets written to the link register R7. The sequencer presents one instruction word at a time with an issue strobe. Alongside it come the already incremented PC, the value of the general register named by instruction bits 8..6, and the read data port of the memory. The unit answers with a PC load strobe and target, an R7 write strobe and value, and a memory read request for the service-routine table.

A subroutine call takes one cycle. Instruction bit 11 chooses between a PC-relative target and a register target. A register jump also takes one cycle, and a jump through R7 is how a routine returns. A trap takes two cycles. In the first cycle the 8-bit vector, zero-extended, addresses the start-address table at the bottom of memory (0x0000..0x00FF), and the PC is held. In the second cycle the table word arrives and is loaded into the PC, and R7 receives the return address that was captured in the first cycle. Any other opcode simply loads the incremented PC.

Top module: `xfer_target_unit`

## Requirements
- R1: After reset is released, `busy`, `pc_load`, `link_we` and `mem_re` are all low until an instruction is issued.
- R2: In the cycle a trap (opcode bits 15..12 = 1111) is issued, `mem_re` is high and `mem_addr` equals IR[7:0] zero-extended to 16 bits. In that same cycle `pc_load` and `link_we` are low.
- R3: In the cycle after a trap issue, `busy`, `pc_load` and `link_we` are high. `pc_next` equals `mem_rdata` of that cycle, and `link_data` equals the `pc_inc` presented with the trap.
- R4: `issue` is ignored while `busy` is high. The outputs in that cycle are exactly those of R3, and `busy` is low in the following cycle.
- R5: A call (opcode 0100) with IR[11]=1 loads `pc_next` = `pc_inc` + sign-extended IR[10:0], and writes `pc_inc` to R7 in the same cycle.
- R6: A call with IR[11]=0 loads `pc_next` = `reg_val` and writes `pc_inc` to R7. `rf_sel` always equals IR[8:6].
- R7: A jump (opcode 1100) loads `pc_next` = `reg_val` and does not write R7.
- R8: Any other opcode loads `pc_next` = `pc_inc`, with no R7 write and no memory read.
- R9: With `issue` low and `busy` low, `pc_load`, `link_we` and `mem_re` are low.
- R10: The PC-relative sum wraps modulo 2^16 at both ends of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction word is presented this cycle |
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the following instruction |
| reg_val | input | 16 | Register file value for register `rf_sel` |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |
| rf_sel | output | 3 | Register index to read (IR[8:6]) |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 16 | New PC value |
| link_we | output | 1 | Write `link_data` to R7 |
| link_data | output | 16 | Return address |
| mem_re | output | 1 | Table read request |
| mem_addr | output | 16 | Table read address |
| busy | output | 1 | Trap table fetch completing; issue ignored |

## Verification
The properties assume a memory that returns the addressed word on `mem_rdata` exactly one cycle after `mem_re`. They also assume that `reg_val` already holds the register selected by `rf_sel` in the same cycle. The bench models a one-cycle table memory whose contents are a fixed function of the address, and drives `reg_val` as a free value, because the unit only forwards it. The stimulus also keeps `issue` raised during some busy cycles, to show that such issues are ignored.

// File: rtl/xfer_target_unit.sv
module xfer_target_unit #(
  parameter int W   = 16,
  parameter int VW  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [W-1:0] ir,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] mem_rdata,
  output logic [2:0]   rf_sel,
  output logic         pc_load,
  output logic [W-1:0] pc_next,
  output logic         link_we,
  output logic [W-1:0] link_data,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic         busy
);
  localparam logic [3:0] OP_TRAP = 4'b1111;
  localparam logic [3:0] OP_CALL = 4'b0100;
  localparam logic [3:0] OP_JUMP = 4'b1100;
  localparam int OFFW = 11;
  localparam int MODE_BIT = 11;

  logic         fetch_q;
  logic [W-1:0] ret_q;

  wire [3:0] opc   = ir[W-1 -: 4];
  wire       go    = issue & ~fetch_q;
  wire       t_trp = go & (opc == OP_TRAP);
  wire       t_cal = go & (opc == OP_CALL);
  wire       t_jmp = go & (opc == OP_JUMP);
  wire       use_reg = t_jmp | (t_cal & ~ir[MODE_BIT]);

  wire [W-1:0] rel_tgt = pc_inc + {{(W-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      ret_q   <= '0;
    end else begin
      fetch_q <= t_trp;
      if (t_trp) ret_q <= pc_inc;
    end
  end

  assign rf_sel    = ir[8:6];
  assign busy      = fetch_q;
  assign mem_re    = t_trp;
  assign mem_addr  = {{(W-VW){1'b0}}, ir[VW-1:0]};
  assign pc_load   = fetch_q | (go & (opc != OP_TRAP));
  assign pc_next   = fetch_q ? mem_rdata :
                     use_reg ? reg_val   :
                     t_cal   ? rel_tgt   : pc_inc;
  assign link_we   = fetch_q | t_cal;
  assign link_data = fetch_q ? ret_q : pc_inc;
endmodule

// File: rtl/xfer_target_unit_chk.sv
module xfer_target_unit_chk #(
  parameter int W  = 16,
  parameter int VW = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [W-1:0] ir,
  input logic [W-1:0] pc_inc,
  input logic [W-1:0] reg_val,
  input logic [W-1:0] mem_rdata,
  input logic         pc_load,
  input logic [W-1:0] pc_next,
  input logic         link_we,
  input logic [W-1:0] link_data,
  input logic         mem_re,
  input logic [W-1:0] mem_addr,
  input logic         busy
);
  wire [3:0] op  = ir[W-1 -: 4];
  wire       acc = issue && !busy;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !busy);

  a_r2_trap_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'b1111) |-> (mem_re && !pc_load && !link_we &&
      mem_addr[W-1:VW] == '0 && mem_addr[VW-1:0] == ir[VW-1:0]));

  a_r3_trap_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'b1111) |=> (busy && pc_load && link_we &&
      pc_next == mem_rdata && link_data == $past(pc_inc)));

  a_r4_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r5_call_links: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'b0100) |-> (pc_load && link_we && link_data == pc_inc && !mem_re));

  a_r7_jump_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'b1100) |-> (pc_load && pc_next == reg_val && !link_we));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !busy) |-> (!pc_load && !link_we && !mem_re));
endmodule

bind xfer_target_unit xfer_target_unit_chk #(.W(W), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .ir(ir), .pc_inc(pc_inc),
  .reg_val(reg_val), .mem_rdata(mem_rdata), .pc_load(pc_load),
  .pc_next(pc_next), .link_we(link_we), .link_data(link_data),
  .mem_re(mem_re), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/xfer_target_unit_tb_top.sv
`timescale 1ns/1ps
module xfer_target_unit_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic issue = 0;
  logic [15:0] ir = 0, pc_inc = 0, reg_val = 0, mem_rdata = 0;
  logic [2:0]  rf_sel;
  logic pc_load, link_we, mem_re, busy;
  logic [15:0] pc_next, link_data, mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_busy = 0;
  logic [15:0] m_ret = 0;
  bit          m_rd = 0;
  logic [15:0] m_raddr = 0;

  always #2.5 clk = ~clk;

  xfer_target_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .ir(ir), .pc_inc(pc_inc),
    .reg_val(reg_val), .mem_rdata(mem_rdata), .rf_sel(rf_sel),
    .pc_load(pc_load), .pc_next(pc_next), .link_we(link_we),
    .link_data(link_data), .mem_re(mem_re), .mem_addr(mem_addr), .busy(busy)
  );

  function automatic logic [15:0] tbl(input logic [15:0] a);
    return (a * 16'h0101) ^ 16'h3000;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit iss, input logic [15:0] instr, input logic [15:0] pc, input logic [15:0] rv);
    bit e_ld, e_lk, e_rd, e_bz;
    logic [15:0] e_pc, e_lnk, e_ad;
    string tag;
    int op;
    @(negedge clk);
    issue = iss; ir = instr; pc_inc = pc; reg_val = rv;
    mem_rdata = m_rd ? tbl(m_raddr) : 16'hBAD0 ^ pc;
    #1;
    e_ld = 0; e_lk = 0; e_rd = 0; e_bz = m_busy; e_pc = 0; e_lnk = 0; e_ad = 0;
    op = int'(instr[15:12]);
    if (m_busy) begin
      tag = iss ? "R4" : "R3";
      e_ld = 1; e_pc = tbl(m_raddr); e_lk = 1; e_lnk = m_ret;
    end else if (!iss) begin
      tag = "R9";
    end else if (op == 15) begin
      tag = "R2"; e_rd = 1; e_ad = 16'(instr[7:0]);
    end else if (op == 4) begin
      e_ld = 1; e_lk = 1; e_lnk = pc;
      if (instr[11]) begin
        tag = "R5"; e_pc = 16'(int'(pc) + int'($signed(instr[10:0])));
      end else begin
        tag = "R6"; e_pc = rv;
      end
    end else if (op == 12) begin
      tag = "R7"; e_ld = 1; e_pc = rv;
    end else begin
      tag = "R8"; e_ld = 1; e_pc = pc;
    end
    chk(tag, "pc_load", 16'(pc_load), 16'(e_ld));
    chk(tag, "link_we", 16'(link_we), 16'(e_lk));
    chk(tag, "mem_re", 16'(mem_re), 16'(e_rd));
    chk(tag, "busy", 16'(busy), 16'(e_bz));
    chk("R6", "rf_sel", 16'(rf_sel), 16'(instr[8:6]));
    if (e_ld) chk(tag, "pc_next", pc_next, e_pc);
    if (e_lk) chk(tag, "link_data", link_data, e_lnk);
    if (e_rd) chk(tag, "mem_addr", mem_addr, e_ad);
    @(posedge clk);
    if (m_busy) m_busy = 0;
    else if (iss && op == 15) begin m_busy = 1; m_ret = pc; end
    m_rd = e_rd; m_raddr = e_ad;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", "busy", 16'(busy), 0);
    chk("R1", "pc_load", 16'(pc_load), 0);
    chk("R1", "link_we", 16'(link_we), 0);
    chk("R1", "mem_re", 16'(mem_re), 0);
    cyc(0, 16'h0000, 16'h3001, 16'h1111);
    // traps, including extreme vectors; R4: issue held during busy
    cyc(1, 16'hF025, 16'h3005, 16'h0);
    cyc(0, 16'h0, 16'h0, 16'h0);
    cyc(1, 16'hF000, 16'h4000, 16'h0);
    cyc(1, 16'h4FFF, 16'h4100, 16'h2222);
    cyc(1, 16'hF0FF, 16'hFFFF, 16'h0);
    cyc(1, 16'hC1C0, 16'h1234, 16'h5555);
    // calls: PC-relative and register, wrap (R10)
    cyc(1, 16'h4800 | 16'h03FF, 16'h3000, 16'h0);
    cyc(1, 16'h4C00, 16'h3000, 16'h0);
    cyc(1, 16'h4BFF, 16'h0000, 16'h0);
    cyc(1, 16'h4801, 16'hFFFF, 16'h0);
    cyc(1, 16'h4100, 16'h3010, 16'hABCD);
    cyc(1, 16'h41C0, 16'h3011, 16'h7777);
    // jumps, R7 return
    cyc(1, 16'hC1C0, 16'h3020, 16'h3055);
    cyc(1, 16'hC080, 16'h3021, 16'h8000);
    // other opcodes
    for (int k = 0; k < 16; k++) cyc(1, 16'(k << 12) | 16'h0ABC, 16'(16'h5000 + k), 16'h9999);
    // randomized mix
    for (int k = 0; k < 400; k++)
      cyc(($urandom % 4) != 0, 16'($urandom), 16'($urandom), 16'($urandom));
    // reset in the middle of a trap
    cyc(1, 16'hF021, 16'h3100, 16'h0);
    @(negedge clk); rst_n = 0; issue = 0;
    @(posedge clk);
    @(negedge clk); rst_n = 1; m_busy = 0; m_rd = 0;
    #1;
    chk("R1", "busy", 16'(busy), 0);
    cyc(0, 16'h0, 16'h0, 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule